// File: doc/BRIEF.md
# Keyed-Refresh Lockdown Watchdog

This block is a hardened watchdog timer on a small register bus (address, write data, write strobe). Software first sets a timeout, then arms the timer with a write to a dedicated arm register. After that, nothing on the bus can turn it off; only the system reset input returns it to the disarmed state. The timeout value is frozen at the moment of arming.

The countdown is refreshed only by a two-write keyed sequence: a first key word written to the first refresh address, followed by a second key word written to a second refresh address, with no other bus write between them. A write with the wrong word to either refresh address is taken as evidence of runaway software and bites the watchdog at once. On a bite the block pulses an internal reset request for one cycle and drives an external reset-out line for a fixed, parameterised number of cycles. It then reloads the countdown and keeps running, still armed.

Top module: `keyed_wdt`

## Requirements
- R1: After `rst_n` is released, `rst_out` and `core_rst` are 0 and the timer is disarmed.
- R2: A write to `ADDR_ARM` (default 1) with data bit 0 set arms the timer and loads the countdown with the timeout. With no refresh, the bite comes T+1 cycles after the arming edge, where T is the timeout. A write to `ADDR_ARM` with bit 0 clear before arming has no effect.
- R3: Once armed, no bus write can disarm the timer. A later write of 0 to `ADDR_ARM` leaves the bite schedule unchanged.
- R4: A write to `ADDR_CFG` (default 0) sets the timeout from the low TW data bits, but only while disarmed. Writes to `ADDR_CFG` after arming are ignored.
- R5: A refresh occurs when `KEY1` (default 0x005A) is written to `ADDR_KICK1` (default 2) and the next bus write is `KEY2` (default 0x00A5) to `ADDR_KICK2` (default 3). Idle cycles between the two writes are allowed. The refresh reloads the countdown on the second write's edge, and the bite follows T+1 cycles later.
- R6: Any bus write other than the completing `KEY2` write, made after a correct first step, cancels the sequence. This includes a repeated `KEY1` to `ADDR_KICK1`. A following `KEY2` write then does not refresh.
- R7: `KEY2` written to `ADDR_KICK2` without a preceding first step neither refreshes nor bites.
- R8: While armed and not in a reset-out window, a write of any value other than its key to `ADDR_KICK1` or `ADDR_KICK2` bites on that same edge.
- R9: On a bite, `core_rst` is high for exactly the first cycle, and `rst_out` is high for exactly RST_HOLD consecutive cycles starting in that cycle.
- R10: Bus writes during the reset-out window are ignored. When the window ends, the countdown reloads with T, the timer stays armed, and the next bite without refresh follows T+1 cycles after the window's end edge.
- R11: While disarmed, writes to the refresh addresses, including wrong values, cause no bite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, the only way to disarm |
| bus_addr | input | AW | Register address of the current write |
| bus_wdata | input | DW | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| core_rst | output | 1 | One-cycle internal reset request on a bite |
| rst_out | output | 1 | External reset-out, held RST_HOLD cycles per bite |

## Verification
Some cases are hard to reach. The first is a write that lands inside the reset-out window. The second is a correct refresh sequence spoiled by a single foreign write between the two steps. The third is a lone second-step key. None of these is visible except as a shift in when the next bite happens. The stimulus arms the timer with a short timeout and times each write relative to the previous bite or refresh edge. It places one write a few cycles into a hold window, and splices an unrelated write or a lone key between valid refreshes. The scoreboard then predicts the exact cycle of every later bite, so any spurious reload shows up as a mismatched rise cycle.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_PRIMED = 1'b1
    } seq_e;
endpackage

// File: rtl/kwdt_kick_seq.sv
module kwdt_kick_seq
    import kwdt_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16,
    parameter logic [AW-1:0] ADDR_KICK1 = 2,
    parameter logic [AW-1:0] ADDR_KICK2 = 3,
    parameter logic [DW-1:0] KEY1 = 16'h005A,
    parameter logic [DW-1:0] KEY2 = 16'h00A5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          kick,
    output logic          fault
);
    seq_e seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        kick  = 1'b0;
        fault = 1'b0;
        if (!en) begin
            seq_d = SEQ_IDLE;
        end else if (we) begin
            seq_d = SEQ_IDLE;
            if (addr == ADDR_KICK1) begin
                if (wdata != KEY1) fault = 1'b1;
                else if (seq_q == SEQ_IDLE) seq_d = SEQ_PRIMED;
            end else if (addr == ADDR_KICK2) begin
                if (wdata != KEY2) fault = 1'b1;
                else kick = (seq_q == SEQ_PRIMED);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_IDLE;
        else        seq_q <= seq_d;
    end
endmodule

// File: rtl/kwdt_countdown.sv
module kwdt_countdown #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                       cnt_d = load_val;
        else if (run && cnt_q != '0)    cnt_d = cnt_q - 1'b1;
        expired = run && !load && (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
    parameter int AW = 4,
    parameter int DW = 16,
    parameter int TW = 16,
    parameter int RST_HOLD = 64,
    parameter int DEFAULT_TIMEOUT = 1000,
    parameter logic [AW-1:0] ADDR_CFG   = 0,
    parameter logic [AW-1:0] ADDR_ARM   = 1,
    parameter logic [AW-1:0] ADDR_KICK1 = 2,
    parameter logic [AW-1:0] ADDR_KICK2 = 3,
    parameter logic [DW-1:0] KEY1 = 16'h005A,
    parameter logic [DW-1:0] KEY2 = 16'h00A5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    output logic          core_rst,
    output logic          rst_out
);
    localparam int HW = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(RST_HOLD - 1);

    typedef struct packed {
        logic          armed;
        logic [TW-1:0] timeout;
        logic [HW-1:0] hold_cnt;
        logic          rst_out;
        logic          core_rst;
    } wdt_state_t;

    wdt_state_t st_d, st_q;

    logic running, arm_set, hold_done, reload;
    logic kick_w, fault_w, expired_w, bite;
    logic armed_w;
    logic [TW-1:0] timeout_w;

    assign running   = st_q.armed && !st_q.rst_out;
    assign arm_set   = !st_q.armed && bus_we && (bus_addr == ADDR_ARM) && bus_wdata[0];
    assign hold_done = st_q.rst_out && (st_q.hold_cnt == '0);
    assign reload    = arm_set || kick_w || hold_done;
    assign bite      = running && (fault_w || expired_w);

    kwdt_kick_seq #(
        .AW(AW), .DW(DW),
        .ADDR_KICK1(ADDR_KICK1), .ADDR_KICK2(ADDR_KICK2),
        .KEY1(KEY1), .KEY2(KEY2)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .en(running),
        .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .kick(kick_w), .fault(fault_w)
    );

    kwdt_countdown #(.CW(TW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(running),
        .load(reload), .load_val(st_q.timeout),
        .expired(expired_w)
    );

    always_comb begin
        st_d = st_q;
        st_d.core_rst = 1'b0;
        if (!st_q.armed && bus_we && bus_addr == ADDR_CFG)
            st_d.timeout = bus_wdata[TW-1:0];
        if (arm_set)
            st_d.armed = 1'b1;
        if (st_q.rst_out) begin
            if (hold_done) st_d.rst_out = 1'b0;
            else           st_d.hold_cnt = st_q.hold_cnt - 1'b1;
        end else if (bite) begin
            st_d.rst_out  = 1'b1;
            st_d.core_rst = 1'b1;
            st_d.hold_cnt = HOLD_LAST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.armed    <= 1'b0;
            st_q.timeout  <= TW'(DEFAULT_TIMEOUT);
            st_q.hold_cnt <= '0;
            st_q.rst_out  <= 1'b0;
            st_q.core_rst <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_w   = st_q.armed;
    assign timeout_w = st_q.timeout;
    assign core_rst  = st_q.core_rst;
    assign rst_out   = st_q.rst_out;
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
    parameter int TW = 16,
    parameter int RST_HOLD = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          armed,
    input logic [TW-1:0] timeout,
    input logic          fault,
    input logic          core_rst,
    input logic          rst_out
);
    localparam int LW = $clog2(RST_HOLD + 1) + 1;
    localparam logic [LW-1:0] HOLD_L = LW'(RST_HOLD);

    logic [LW-1:0] len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       len_q <= '0;
        else if (rst_out) len_q <= len_q + 1'b1;
        else              len_q <= '0;
    end

    a_r3_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(armed) |-> armed);
    a_r4_timeout_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(armed)) |-> $stable(timeout));
    a_r11_quiet_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (!rst_out && !core_rst));
    a_r8_fault_bites: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !rst_out) |=> (rst_out && core_rst));
    a_r9_core_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> (rst_out && len_q == '0));
    a_r9_core_single: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> !core_rst);
    a_r9_hold_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |-> (len_q < HOLD_L));
    a_r9_hold_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> (len_q == HOLD_L));
endmodule

bind keyed_wdt kwdt_checker #(.TW(TW), .RST_HOLD(RST_HOLD)) u_chk (
    .clk(clk), .rst_n(rst_n), .armed(armed_w), .timeout(timeout_w),
    .fault(fault_w), .core_rst(core_rst), .rst_out(rst_out)
);

// File: tb/keyed_wdt_test.sv
`timescale 1ns/1ps
module keyed_wdt_test;
    localparam int HOLD = 8;
    localparam int T    = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        we = 1'b0;
    logic        core_rst, rst_out;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    int rises = 0;
    int pushes = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    keyed_wdt #(.RST_HOLD(HOLD), .DEFAULT_TIMEOUT(100)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
        .bus_we(we), .core_rst(core_rst), .rst_out(rst_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, output int e);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        e = cyc;
        we = 1'b0; wdata = '0;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic expect_bite(input int c);
        exp_q.push_back(c);
        pushes++;
    endtask

    // Monitor: records each reset-out window and compares it with the queue.
    int rise_cyc = 0;
    bit prev_out = 1'b0;
    bit just_rose = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (just_rose) check(core_rst == 1'b0, "R9 core_rst one cycle", core_rst, 0);
            just_rose = 1'b0;
            if (rst_out && !prev_out) begin
                rise_cyc = cyc;
                rises++;
                just_rose = 1'b1;
                check(core_rst == 1'b1, "R9 core_rst with rise", core_rst, 1);
            end
            if (!rst_out && prev_out) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11/R7 unexpected bite", rise_cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(rise_cyc == e, "R2/R5/R8/R10 bite cycle", rise_cyc, e);
                    check(cyc - rise_cyc == HOLD, "R9 hold length", cyc - rise_cyc, HOLD);
                end
            end
            prev_out = rst_out;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int e, k, r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rst_out == 1'b0, "R1 rst_out after reset", rst_out, 0);
        check(core_rst == 1'b0, "R1 core_rst after reset", core_rst, 0);

        // R11 / R2: disarmed, wrong keys and a cleared arm bit do nothing
        wr(4'd2, 16'h0011, e);
        wr(4'd3, 16'h0022, e);
        wr(4'd1, 16'h0000, e);
        wr(4'd2, 16'h005A, e);
        wr(4'd3, 16'h00A5, e);
        wait_to(cyc + 200);
        check(rises == 0, "R11 no bite while disarmed", rises, 0);

        // R4 timeout set, R2 arm, R3/R4 later writes ignored
        wr(4'd0, 16'(T), e);
        wr(4'd1, 16'h0001, e);
        r = e + T + 1;
        expect_bite(r);
        wr(4'd0, 16'h0005, e);
        wr(4'd1, 16'h0000, e);
        // R10: a wrong key inside the hold window is ignored
        wait_to(r + 1);
        wr(4'd2, 16'h0000, e);
        expect_bite(r + HOLD + T + 1);
        r = r + HOLD + T + 1;
        wait_to(r + HOLD + 2);

        // R5 refresh with idle gap, R7 lone second key
        wr(4'd2, 16'h005A, e);
        repeat (2) @(negedge clk);
        wr(4'd3, 16'h00A5, k);
        wait_to(k + 10);
        wr(4'd3, 16'h00A5, e);
        expect_bite(k + T + 1);
        wait_to(k + T + 1 + HOLD + 2);

        // R6 foreign write between steps cancels the sequence
        wr(4'd2, 16'h005A, e);
        wr(4'd3, 16'h00A5, k);
        wait_to(k + 5);
        wr(4'd2, 16'h005A, e);
        wr(4'd0, 16'h0003, e);
        wr(4'd3, 16'h00A5, e);
        wait_to(k + 20);
        wr(4'd2, 16'h005A, e);
        wr(4'd2, 16'h005A, e);
        wr(4'd3, 16'h00A5, e);
        expect_bite(k + T + 1);
        wait_to(k + T + 1 + HOLD + 2);

        // R8 wrong value at either refresh address bites at once
        wr(4'd2, 16'h005B, e);
        expect_bite(e);
        wait_to(e + HOLD + 2);
        wr(4'd2, 16'h005A, e);
        wr(4'd3, 16'h00A4, e);
        expect_bite(e);
        wait_to(e + HOLD + 3);

        check(exp_q.size() == 0, "R9 all windows seen", exp_q.size(), 0);
        check(rises == pushes, "R3 bite count", rises, pushes);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule